// File: doc/BRIEF.md
# Iterative Radix-4 Non-Restoring Integer Divider

This block divides one 32-bit integer by another and returns both the quotient and the remainder. The operands can be treated as unsigned or as two's-complement values. A single one-cycle `start` pulse hands over the operands while the unit is idle. After a fixed number of cycles the unit raises `done` for one cycle, and the results are then valid on the output ports.

Inside, the unit has one combinational iteration stage that retires two quotient bits per clock. It is used sixteen times over on magnitudes that are formed in a setup cycle. One cycle then folds a negative final partial remainder back into range. Another cycle applies the operand signs, so that the quotient truncates toward zero and the remainder follows the dividend. A zero divisor does not shorten the sequence. It is flagged on its own output, and both results are forced to zero.

A request always completes in 20 cycles, whatever the operand values. The unit can therefore sit in a fixed-latency execution slot, and the issue logic can count cycles instead of watching a handshake.

Top module: `iter_div4`

## Requirements
- R1: With `signed_mode` low and a nonzero divisor, `quotient` is the floor of dividend/divisor and `remainder` is dividend minus quotient times divisor, both taken as unsigned 32-bit values.
- R2: With `signed_mode` high and a nonzero divisor, the operands are two's complement. `quotient` is rounded toward zero. `remainder` is zero or carries the sign of the dividend, and its magnitude is below that of the divisor.
- R3: In signed mode, 0x80000000 divided by 0xFFFFFFFF yields `quotient` 0x80000000, which is the true result truncated to 32 bits, and `remainder` 0.
- R4: A divisor of zero gives `div_by_zero` = 1 with `quotient` = 0 and `remainder` = 0, and keeps the same latency. Any nonzero divisor gives `div_by_zero` = 0.
- R5: `done` is high in exactly one cycle, and that cycle follows the 20th rising edge after the edge that sampled `start` high while idle.
- R6: `done` is a single-cycle pulse. `quotient`, `remainder` and `div_by_zero` hold their values until the next completion.
- R7: A `start` pulse while a division is in progress is ignored. The running division keeps its operands and its timing, and no extra `done` follows.
- R8: While `rst_n` is low and after its release, `done`, `div_by_zero`, `quotient` and `remainder` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only while idle |
| dividend | input | 32 | Dividend, sampled with an accepted start |
| divisor | input | 32 | Divisor, sampled with an accepted start |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient of the last completed division |
| remainder | output | 32 | Remainder of the last completed division |
| div_by_zero | output | 1 | Set when the last division had a zero divisor |

## Verification
The bench targets these corner cases:

- The most negative value divided by minus one. A unit that saturated or trapped would return 0x7FFFFFFF or a nonzero remainder.
- Every sign combination. A missing sign fix-up would return a positive quotient for mixed signs, or a remainder with the divisor's sign.
- Operands such as all-ones divided by all-ones, and a high-bit-set unsigned dividend. An undersized partial remainder would overflow on these and corrupt both results.
- A zero divisor, and a start pulse issued mid-run. These expose a unit that terminates early, leaves residue in the results, or restarts on a new request and drops the result of the running one.

// File: rtl/div4_pkg.sv
package div4_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ITER,
    ST_RESTORE,
    ST_SIGN,
    ST_OUT
  } div_state_e;

  // cycles outside the iteration loop: setup, restore, sign fix, output
  localparam int FIXED_STEPS = 4;
endpackage

// File: rtl/div4_prep.sv
// Operand conditioning: magnitudes and result sign decisions.
module div4_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dsr,
  input  logic         sgn,
  output logic [W-1:0] mag_dvd,
  output logic [W-1:0] mag_dsr,
  output logic         neg_q,
  output logic         neg_r,
  output logic         zero_dsr
);
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic s);
    magnitude = (s && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  assign mag_dvd  = magnitude(dvd, sgn);
  assign mag_dsr  = magnitude(dsr, sgn);
  assign neg_q    = sgn && (dvd[W-1] ^ dsr[W-1]);
  assign neg_r    = sgn && dvd[W-1];
  assign zero_dsr = (dsr == '0);
endmodule

// File: rtl/div4_stage.sv
// One loop pass: BITS chained non-restoring steps (BITS=2 gives radix 4).
module div4_stage #(
  parameter int W    = 32,
  parameter int BITS = 2
) (
  input  logic [W+1:0] rem_in,
  input  logic [W-1:0] qsh_in,
  input  logic [W-1:0] dsr,
  output logic [W+1:0] rem_out,
  output logic [W-1:0] qsh_out
);
  // shift in one dividend bit, then subtract or add back depending on sign
  function automatic logic [W+1:0] nr_step(input logic [W+1:0] r, input logic b,
                                           input logic [W-1:0] d);
    logic [W+1:0] sh;
    sh = {r[W:0], b};
    if (r[W+1]) nr_step = sh + {2'b00, d};
    else        nr_step = sh - {2'b00, d};
  endfunction

  logic [W+1:0] rem_chain [BITS+1];
  logic [W-1:0] q_chain   [BITS+1];

  assign rem_chain[0] = rem_in;
  assign q_chain[0]   = qsh_in;

  for (genvar i = 0; i < BITS; i++) begin : g_step
    assign rem_chain[i+1] = nr_step(rem_chain[i], q_chain[i][W-1], dsr);
    assign q_chain[i+1]   = {q_chain[i][W-2:0], ~rem_chain[i+1][W+1]};
  end

  assign rem_out = rem_chain[BITS];
  assign qsh_out = q_chain[BITS];
endmodule

// File: rtl/div4_fixup.sv
// Remainder restore and final sign application.
module div4_fixup #(
  parameter int W = 32
) (
  input  logic [W+1:0] rem,
  input  logic [W-1:0] qv,
  input  logic [W-1:0] dsr,
  input  logic         neg_q,
  input  logic         neg_r,
  input  logic         zero_dsr,
  output logic [W-1:0] rem_fix,
  output logic [W-1:0] q_fin,
  output logic [W-1:0] r_fin
);
  function automatic logic [W-1:0] restore(input logic [W+1:0] r, input logic [W-1:0] d);
    logic [W+1:0] sum;
    sum = r + {2'b00, d};
    restore = r[W+1] ? sum[W-1:0] : r[W-1:0];
  endfunction

  function automatic logic [W-1:0] apply_sign(input logic [W-1:0] v, input logic n,
                                              input logic z);
    if (z)      apply_sign = '0;
    else if (n) apply_sign = ~v + 1'b1;
    else        apply_sign = v;
  endfunction

  assign rem_fix = restore(rem, dsr);
  assign q_fin   = apply_sign(qv, neg_q, zero_dsr);
  assign r_fin   = apply_sign(rem[W-1:0], neg_r, zero_dsr);
endmodule

// File: rtl/iter_div4.sv
module iter_div4 #(
  parameter int WIDTH = 32,
  parameter int BITS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             signed_mode,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);
  import div4_pkg::*;

  localparam int ITERS   = WIDTH / BITS;
  localparam int CNT_W   = $clog2(ITERS);
  localparam int LATENCY = ITERS + FIXED_STEPS;
  localparam int LAT_W   = $clog2(LATENCY + 1);

  div_state_e       state;
  logic [CNT_W-1:0] iter_cnt;
  logic [LAT_W-1:0] lat_cnt;
  logic [WIDTH-1:0] dvd_raw, dsr_raw;
  logic             sgn_raw;
  logic [WIDTH-1:0] qreg, dsr_mag;
  logic [WIDTH+1:0] rem;
  logic             neg_q_r, neg_r_r, zero_r;

  // named internal events
  logic             accept;
  logic             last_iter;
  assign accept    = start && (state == ST_IDLE);
  assign last_iter = (state == ST_ITER) && (iter_cnt == CNT_W'(ITERS - 1));

  logic [WIDTH-1:0] mag_dvd, mag_dsr;
  logic             neg_q, neg_r, zero_dsr;
  div4_prep #(.W(WIDTH)) prep_i (
    .dvd(dvd_raw), .dsr(dsr_raw), .sgn(sgn_raw),
    .mag_dvd(mag_dvd), .mag_dsr(mag_dsr),
    .neg_q(neg_q), .neg_r(neg_r), .zero_dsr(zero_dsr)
  );

  logic [WIDTH+1:0] rem_next;
  logic [WIDTH-1:0] q_next;
  div4_stage #(.W(WIDTH), .BITS(BITS)) stage_i (
    .rem_in(rem), .qsh_in(qreg), .dsr(dsr_mag),
    .rem_out(rem_next), .qsh_out(q_next)
  );

  logic [WIDTH-1:0] rem_fix, q_fin, r_fin;
  div4_fixup #(.W(WIDTH)) fix_i (
    .rem(rem), .qv(qreg), .dsr(dsr_mag),
    .neg_q(neg_q_r), .neg_r(neg_r_r), .zero_dsr(zero_r),
    .rem_fix(rem_fix), .q_fin(q_fin), .r_fin(r_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      iter_cnt    <= '0;
      lat_cnt     <= '0;
      dvd_raw     <= '0;
      dsr_raw     <= '0;
      sgn_raw     <= 1'b0;
      qreg        <= '0;
      dsr_mag     <= '0;
      rem         <= '0;
      neg_q_r     <= 1'b0;
      neg_r_r     <= 1'b0;
      zero_r      <= 1'b0;
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state != ST_IDLE) lat_cnt <= lat_cnt + 1'b1;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            dvd_raw <= dividend;
            dsr_raw <= divisor;
            sgn_raw <= signed_mode;
            lat_cnt <= '0;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          qreg     <= mag_dvd;
          dsr_mag  <= mag_dsr;
          rem      <= '0;
          neg_q_r  <= neg_q;
          neg_r_r  <= neg_r;
          zero_r   <= zero_dsr;
          iter_cnt <= '0;
          state    <= ST_ITER;
        end
        ST_ITER: begin
          rem      <= rem_next;
          qreg     <= q_next;
          iter_cnt <= iter_cnt + 1'b1;
          if (last_iter) state <= ST_RESTORE;
        end
        ST_RESTORE: begin
          rem   <= {2'b00, rem_fix};
          state <= ST_SIGN;
        end
        ST_SIGN: begin
          qreg  <= q_fin;
          rem   <= {2'b00, r_fin};
          state <= ST_OUT;
        end
        ST_OUT: begin
          quotient    <= qreg;
          remainder   <= rem[WIDTH-1:0];
          div_by_zero <= zero_r;
          done        <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == LAT_W'(LATENCY)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(dvd_raw) && $stable(dsr_raw) && $stable(sgn_raw)));

  // R1
  restore_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESTORE) |=>
      (rem[WIDTH+1:WIDTH] == 2'b00) && (zero_r || (rem[WIDTH-1:0] < dsr_mag)));

  // R4
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (quotient == '0 && remainder == '0));
endmodule

// File: tb/iter_div4_tb_top.sv
`timescale 1ns/1ps
module iter_div4_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic        signed_mode = 1'b0;
  logic        done, div_by_zero;
  logic [31:0] quotient, remainder;

  int total = 0;
  int fails = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  iter_div4 dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor), .signed_mode(signed_mode),
    .done(done), .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // {signed, dividend, divisor, quotient, remainder, div_by_zero}
  localparam int NV = 16;
  localparam logic [129:0] VEC [NV] = '{
    {1'b0, 32'd100,        32'd7,          32'd14,         32'd2,          1'b0},
    {1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0,          1'b0},
    {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'd1,          32'd0,          1'b0},
    {1'b0, 32'd5,          32'd9,          32'd0,          32'd5,          1'b0},
    {1'b0, 32'h80000000,   32'h10,         32'h08000000,   32'd0,          1'b0},
    {1'b0, 32'hFFFFFFFF,   32'h10000,      32'h0000FFFF,   32'h0000FFFF,   1'b0},
    {1'b0, 32'h80000000,   32'hFFFFFFFF,   32'd0,          32'h80000000,   1'b0},
    {1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD,   32'hFFFFFFFF,   1'b0},
    {1'b1, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD,   32'd1,          1'b0},
    {1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'd3,          32'hFFFFFFFF,   1'b0},
    {1'b1, 32'd7,          32'd2,          32'd3,          32'd1,          1'b0},
    {1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000,   32'd0,          1'b0},
    {1'b1, 32'h80000000,   32'd1,          32'h80000000,   32'd0,          1'b0},
    {1'b1, 32'h7FFFFFFF,   32'h80000000,   32'd0,          32'h7FFFFFFF,   1'b0},
    {1'b1, 32'd100,        32'd0,          32'd0,          32'd0,          1'b1},
    {1'b0, 32'd0,          32'd0,          32'd0,          32'd0,          1'b1}
  };

  function automatic void ref_div(input logic [31:0] a, input logic [31:0] b, input logic s,
                                  output logic [31:0] q, output logic [31:0] r,
                                  output logic z);
    longint sa, sb;
    if (b == 32'd0) begin
      q = '0; r = '0; z = 1'b1;
    end else if (s) begin
      sa = longint'(signed'(a));
      sb = longint'(signed'(b));
      q = 32'(sa / sb);
      r = 32'(sa % sb);
      z = 1'b0;
    end else begin
      q = a / b; r = a % b; z = 1'b0;
    end
  endfunction

  task automatic check(input logic ok, input string tag, input string what);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // drive one request at a negedge; done expected at the 21st negedge after
  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input logic s,
                         input logic [31:0] eq, input logic [31:0] er, input logic ez,
                         input string tag);
    int first_done;
    int n_done;
    first_done = 0;
    n_done = 0;
    dividend = a; divisor = b; signed_mode = s; start = 1'b1;
    for (int c = 1; c <= 21; c++) begin
      @(negedge clk);
      if (c == 1) begin
        start = 1'b0;
        dividend = ~a; divisor = ~b;
      end
      if (done) begin
        n_done = n_done + 1;
        if (first_done == 0) first_done = c;
      end
    end
    check(first_done == 21 && n_done == 1, "R5",
          $sformatf("done cycle actual %0d (count %0d) expected 21 (count 1)", first_done, n_done));
    check(quotient == eq && remainder == er && div_by_zero == ez, tag,
          $sformatf("%h/%h s=%0b actual q=%h r=%h z=%0b expected q=%h r=%h z=%0b",
                    a, b, s, quotient, remainder, div_by_zero, eq, er, ez));
  endtask

  initial begin
    logic [31:0] eq, er, ra, rb;
    logic        ez;
    repeat (3) @(negedge clk);
    // R8: reset state while held and after release
    check(done == 0 && quotient == 0 && remainder == 0 && div_by_zero == 0, "R8",
          $sformatf("in reset actual done=%0b q=%h r=%h z=%0b expected all 0",
                    done, quotient, remainder, div_by_zero));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 0 && quotient == 0 && remainder == 0 && div_by_zero == 0, "R8",
          $sformatf("after reset actual done=%0b q=%h r=%h z=%0b expected all 0",
                    done, quotient, remainder, div_by_zero));

    // table walk: R1 unsigned, R2 signed, R3 min/-1, R4 zero divisor
    for (int i = 0; i < NV; i++) begin
      logic [129:0] v;
      string tg;
      v = VEC[i];
      if (v[0]) tg = "R4";
      else if (v[129] && v[128:97] == 32'h80000000 && v[96:65] == 32'hFFFFFFFF) tg = "R3";
      else if (v[129]) tg = "R2";
      else tg = "R1";
      run_div(v[128:97], v[96:65], v[129], v[64:33], v[32:1], v[0], tg);
    end

    // R6: outputs hold and done stays low after completion
    repeat (5) @(negedge clk);
    check(done == 0 && quotient == 0 && remainder == 0 && div_by_zero == 1, "R6",
          $sformatf("hold actual done=%0b q=%h r=%h z=%0b expected 0/0/0/1",
                    done, quotient, remainder, div_by_zero));

    // random operands against behavioural division
    for (int i = 0; i < 60; i++) begin
      ra = $urandom;
      rb = (i % 3 == 0) ? ($urandom & 32'h0000FFFF) : $urandom;
      if (rb == 0) rb = 32'd3;
      ref_div(ra, rb, i[0], eq, er, ez);
      run_div(ra, rb, i[0], eq, er, ez, i[0] ? "R2" : "R1");
    end

    // R7: a start pulse mid-run is ignored
    dividend = 32'd1000; divisor = 32'd3; signed_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int first_done;
      int n_done;
      first_done = 0;
      n_done = 0;
      for (int c = 2; c <= 50; c++) begin
        if (c == 6) begin
          dividend = 32'd77; divisor = 32'd0; start = 1'b1;
        end
        @(negedge clk);
        if (c == 6) start = 1'b0;
        if (done) begin
          n_done = n_done + 1;
          if (first_done == 0) first_done = c;
          check(quotient == 32'd333 && remainder == 32'd1 && div_by_zero == 0, "R7",
                $sformatf("actual q=%0d r=%0d z=%0b expected q=333 r=1 z=0",
                          quotient, remainder, div_by_zero));
        end
      end
      check(first_done == 21 && n_done == 1, "R7",
            $sformatf("done cycle actual %0d (count %0d) expected 21 (count 1)",
                      first_done, n_done));
    end

    // R4: nonzero divisor clears the flag again
    run_div(32'd9, 32'd0, 1'b0, 32'd0, 32'd0, 1'b1, "R4");
    run_div(32'd9, 32'd4, 1'b0, 32'd2, 32'd1, 1'b0, "R4");

    // R8: reset mid-run clears outputs and suppresses done
    dividend = 32'd50; divisor = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int n_done;
      n_done = 0;
      for (int c = 0; c < 25; c++) begin
        @(negedge clk);
        if (done) n_done = n_done + 1;
      end
      check(n_done == 0 && quotient == 0 && remainder == 0 && div_by_zero == 0, "R8",
            $sformatf("after mid-run reset actual dones=%0d q=%h r=%h z=%0b expected 0",
                      n_done, quotient, remainder, div_by_zero));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule